// File: doc/BRIEF.md
# Length-Decoded Serial Register Loader

This block is a synchronous serial configuration port. A host lowers an active-low frame enable, clocks data bits in on the rising edges of a serial shift clock, and raises the enable again. At that rising enable edge the block copies the shifted word into one of three holding registers: control, N divider or R divider. No address field is used. The destination is chosen only by how many bits the frame carried. All port inputs are sampled on the system clock, and clock edges are found by comparing each sample with the previous one.

The shift chain has sixteen full stages and an output half-stage. The half-stage captures the last stage on the falling edge of the shift clock and drives a three-state serial output. A host can therefore read its own data back, or feed that output into a second device. The port is controlled by three states. ST_IDLE is the initialized, synchronized rest state. ST_SHIFT holds while a frame is open. ST_LOST is the out-of-sync state.

The transitions are named as follows. open (ST_IDLE to ST_SHIFT) happens when the enable falls while the shift clock is low. commit (ST_SHIFT to ST_IDLE) happens when the enable rises while the shift clock is low. slip (ST_IDLE or ST_SHIFT to ST_LOST) happens when the enable changes while the shift clock is high. resync (ST_LOST to ST_IDLE) happens when the enable is high and the shift clock is low in the same sample.

Top module: `serial_len_loader`

## Requirements
- R1: While the enable is high and the port is synchronized, shift-clock edges are ignored and the chain and bit counter stay cleared. Only the bits of the next frame count toward its length.
- R2: Within a frame, one bit of sdi is shifted in at each rising edge of sclk, most significant bit first.
- R3: A frame of exactly 8 bits loads ctrl_reg with those 8 bits at the commit edge.
- R4: A frame of exactly 16 bits loads n_reg with those 16 bits at the commit edge.
- R5: A frame of 15 or 24 bits loads r_reg with the last 16 chain bits. A 15-bit frame therefore gives a zero in r_reg bit 15, and a 24-bit frame gives its final 16 bits.
- R6: A frame of any other length changes no register. No register changes except at a commit.
- R7: sdo changes only on a falling edge of sclk. The first bit of a frame appears on sdo at the falling edge that follows the 16th rising edge, and later bits follow one per clock. Before that, sdo reads 0 while it is driven.
- R8: sdo_oe is high only while the enable is low and the port is synchronized. sdo is high-impedance whenever sdo_oe is low.
- R9: If the enable changes while sclk is high, the port loses synchronization and the frame is discarded. This covers both a falling enable at the start of a frame and a rising enable at its end.
- R10: Once out of sync, the port stays out of sync until the enable is high and sclk is low in the same sample. A high enable with sclk high does not restore sync, and neither does a low sclk with the enable low.
- R11: A synchronous reset clears all three registers and the bit counter, leaves sdo_oe low, and puts the port in ST_IDLE.
- R12: The bit counter saturates at its maximum (31) rather than wrapping. A 40-bit frame is therefore discarded; it does not alias to an 8-bit length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial shift clock from the host |
| sdi | input | 1 | Serial data in, MSB first |
| en_n | input | 1 | Active-low frame enable |
| sdo | output | 1 | Three-state serial data out from the half-stage |
| sdo_oe | output | 1 | Output enable for sdo |
| ctrl_reg | output | 8 | Control register |
| n_reg | output | 16 | N divider register |
| r_reg | output | 16 | R divider register |

## Verification
The hardest situation to reach is the out-of-sync recovery. It needs the enable to move while sclk is high, and then a series of near-miss exits that must not resync. The stimulus holds sclk high and drops the enable, then raises the enable with sclk still high. Next it lowers sclk with the enable low and clocks a full 8-bit frame that must load nothing. Only then does it raise the enable with sclk low, and a following normal frame must load. A separate sequence clocks seven bits, makes the eighth rising edge, and raises the enable before sclk falls. This shows that a frame of valid length is still discarded when its end edge is illegal.

// File: rtl/sll_pkg.sv
package sll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOST  = 2'd2
    } port_state_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CTRL = 2'd1,
        TGT_N    = 2'd2,
        TGT_R    = 2'd3
    } target_e;

endpackage

// File: rtl/sll_sync_fsm.sv
module sll_sync_fsm
    import sll_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic en_n,
    output logic shift_pulse,
    output logic fall_pulse,
    output logic clear_chain,
    output logic commit,
    output logic port_active
);

    port_state_e state_q;
    port_state_e state_d;
    logic        sclk_q;
    logic        sclk_rise;
    logic        sclk_fall;

    // previous sample of the shift clock for edge detection
    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    assign sclk_rise = sclk & ~sclk_q;
    assign sclk_fall = ~sclk & sclk_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!en_n) state_d = sclk ? ST_LOST : ST_SHIFT;   // slip / open
            end
            ST_SHIFT: begin
                if (en_n) state_d = sclk ? ST_LOST : ST_IDLE;     // slip / commit
            end
            ST_LOST: begin
                if (en_n && !sclk) state_d = ST_IDLE;             // resync
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // outputs
    always_comb begin
        shift_pulse = 1'b0;
        fall_pulse  = 1'b0;
        clear_chain = 1'b0;
        commit      = 1'b0;
        port_active = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                clear_chain = 1'b1;
            end
            ST_SHIFT: begin
                port_active = 1'b1;
                shift_pulse = sclk_rise & ~en_n;
                fall_pulse  = sclk_fall & ~en_n;
                commit      = en_n & ~sclk;
            end
            ST_LOST: begin
                clear_chain = 1'b1;
            end
            default: begin
                clear_chain = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sll_shift_chain.sv
module sll_shift_chain #(
    parameter int CHAIN_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               shift_en,
    input  logic               fall_en,
    input  logic               sdi,
    output logic [CHAIN_W-1:0] chain,
    output logic               dout
);

    logic [CHAIN_W:0] link;
    logic             half_q;

    assign link[0] = sdi;

    // one flop per full stage; stage 0 nearest the input
    for (genvar s = 0; s < CHAIN_W; s++) begin : g_stage
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst || clear)  bit_q <= 1'b0;
            else if (shift_en) bit_q <= link[s];
        end
        assign link[s+1] = bit_q;
        assign chain[s]  = bit_q;
    end

    // half-stage: retimes the last full stage onto the falling shift edge
    always_ff @(posedge clk) begin
        if (rst || clear)  half_q <= 1'b0;
        else if (fall_en)  half_q <= link[CHAIN_W];
    end

    assign dout = half_q;

    assert_half_stage_falling_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(fall_en) && !$past(clear)) |-> $stable(half_q));

endmodule

// File: rtl/sll_len_decode.sv
module sll_len_decode
    import sll_pkg::*;
#(
    parameter int CHAIN_W     = 16,
    parameter int CTRL_W      = 8,
    parameter int LEN_CTRL    = 8,
    parameter int LEN_N       = 16,
    parameter int LEN_R_SHORT = 15,
    parameter int LEN_R_LONG  = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               shift_en,
    input  logic               commit,
    input  logic [CHAIN_W-1:0] chain,
    output logic [CTRL_W-1:0]  ctrl_reg,
    output logic [CHAIN_W-1:0] n_reg,
    output logic [CHAIN_W-1:0] r_reg
);

    localparam int CNT_W   = $clog2(LEN_R_LONG + 1);
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic [CNT_W-1:0] count_q;
    target_e          target;

    // saturating frame length counter
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count_q <= '0;
        end else if (shift_en && (count_q != CNT_W'(CNT_MAX))) begin
            count_q <= count_q + 1'b1;
        end
    end

    always_comb begin
        target = TGT_NONE;
        if (count_q == CNT_W'(LEN_CTRL))
            target = TGT_CTRL;
        else if (count_q == CNT_W'(LEN_N))
            target = TGT_N;
        else if ((count_q == CNT_W'(LEN_R_SHORT)) || (count_q == CNT_W'(LEN_R_LONG)))
            target = TGT_R;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_reg <= '0;
            n_reg    <= '0;
            r_reg    <= '0;
        end else if (commit) begin
            unique case (target)
                TGT_CTRL: ctrl_reg <= chain[CTRL_W-1:0];
                TGT_N:    n_reg    <= chain;
                TGT_R:    r_reg    <= chain;
                TGT_NONE: ;
                default:  ;
            endcase
        end
    end

    assert_regs_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(commit)) |->
            ($stable(ctrl_reg) && $stable(n_reg) && $stable(r_reg)));

    assert_count_saturates_R12: assert property (@(posedge clk) disable iff (rst)
        (shift_en && count_q == CNT_W'(CNT_MAX)) |=> (count_q == CNT_W'(CNT_MAX)));

endmodule

// File: rtl/serial_len_loader.sv
module serial_len_loader
    import sll_pkg::*;
#(
    parameter int CHAIN_W     = 16,
    parameter int CTRL_W      = 8,
    parameter int LEN_CTRL    = 8,
    parameter int LEN_N       = 16,
    parameter int LEN_R_SHORT = 15,
    parameter int LEN_R_LONG  = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk,
    input  logic               sdi,
    input  logic               en_n,
    output logic               sdo,
    output logic               sdo_oe,
    output logic [CTRL_W-1:0]  ctrl_reg,
    output logic [CHAIN_W-1:0] n_reg,
    output logic [CHAIN_W-1:0] r_reg
);

    logic               shift_pulse;
    logic               fall_pulse;
    logic               clear_chain;
    logic               commit;
    logic               port_active;
    logic [CHAIN_W-1:0] chain;
    logic               dout;

    sll_sync_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sclk        (sclk),
        .en_n        (en_n),
        .shift_pulse (shift_pulse),
        .fall_pulse  (fall_pulse),
        .clear_chain (clear_chain),
        .commit      (commit),
        .port_active (port_active)
    );

    sll_shift_chain #(.CHAIN_W(CHAIN_W)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear_chain),
        .shift_en (shift_pulse),
        .fall_en  (fall_pulse),
        .sdi      (sdi),
        .chain    (chain),
        .dout     (dout)
    );

    sll_len_decode #(
        .CHAIN_W     (CHAIN_W),
        .CTRL_W      (CTRL_W),
        .LEN_CTRL    (LEN_CTRL),
        .LEN_N       (LEN_N),
        .LEN_R_SHORT (LEN_R_SHORT),
        .LEN_R_LONG  (LEN_R_LONG)
    ) u_decode (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear_chain),
        .shift_en (shift_pulse),
        .commit   (commit),
        .chain    (chain),
        .ctrl_reg (ctrl_reg),
        .n_reg    (n_reg),
        .r_reg    (r_reg)
    );

    assign sdo_oe = port_active;
    assign sdo    = port_active ? dout : 1'bz;

    assert_oe_needs_low_enable_R8: assert property (@(posedge clk) disable iff (rst)
        $past(en_n) |-> !sdo_oe);

endmodule

// File: tb/serial_len_loader_bench.sv
module serial_len_loader_bench;

    typedef struct {
        string       req;
        logic [7:0]  c;
        logic [15:0] n;
        logic [15:0] r;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        sclk;
    logic        sdi;
    logic        en_n;
    wire         sdo;
    logic        sdo_oe;
    logic [7:0]  ctrl_reg;
    logic [15:0] n_reg;
    logic [15:0] r_reg;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    exp_item_t sb_q[$];
    event      frame_done;
    logic [7:0]  mc = '0;
    logic [15:0] mn = '0;
    logic [15:0] mr = '0;

    always #2 clk = ~clk;   // 250 MHz

    serial_len_loader u_serial_len_loader (
        .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .en_n(en_n),
        .sdo(sdo), .sdo_oe(sdo_oe), .ctrl_reg(ctrl_reg), .n_reg(n_reg), .r_reg(r_reg)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected register contents after each frame
    initial begin
        forever begin
            @(frame_done);
            tick(1);
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                check({it.req, " ctrl"}, {24'h0, ctrl_reg}, {24'h0, it.c});
                check({it.req, " n"},    {16'h0, n_reg},    {16'h0, it.n});
                check({it.req, " r"},    {16'h0, r_reg},    {16'h0, it.r});
            end
        end
    end

    task automatic send_bits(input logic [63:0] w, input int len, input bit chk_loop);
        for (int k = 1; k <= len; k++) begin
            sdi = w[len-k];
            tick(1);
            sclk = 1'b1;
            tick(2);
            if (chk_loop && k == 16)
                check("R7 sdo before falling edge", {31'h0, sdo}, 32'h0);
            sclk = 1'b0;
            tick(2);
            if (chk_loop) begin
                logic expb;
                expb = (k >= 16) ? w[len-(k-15)] : 1'b0;
                check("R7 sdo loop-back", {31'h0, sdo}, {31'h0, expb});
            end
        end
    endtask

    task automatic frame(input string req, input logic [63:0] w, input int len,
                         input bit chk_loop);
        exp_item_t it;
        en_n = 1'b0;
        tick(2);
        check("R8 oe during frame", {31'h0, sdo_oe}, 32'h1);
        send_bits(w, len, chk_loop);
        en_n = 1'b1;
        tick(1);
        if (len == 8)                  mc = w[7:0];
        else if (len == 16)            mn = w[15:0];
        else if (len == 15)            mr = {1'b0, w[14:0]};
        else if (len == 24)            mr = w[15:0];
        it.req = req; it.c = mc; it.n = mn; it.r = mr;
        sb_q.push_back(it);
        ->frame_done;
        tick(4);
        check("R8 oe after frame", {31'h0, sdo_oe}, 32'h0);
    endtask

    task automatic expect_regs(input string req);
        check({req, " ctrl"}, {24'h0, ctrl_reg}, {24'h0, mc});
        check({req, " n"},    {16'h0, n_reg},    {16'h0, mn});
        check({req, " r"},    {16'h0, r_reg},    {16'h0, mr});
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sclk = 1'b0; sdi = 1'b0; en_n = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(2);
        // R11 reset state
        expect_regs("R11 reset");
        check("R11 oe after reset", {31'h0, sdo_oe}, 32'h0);
        check("R8 sdo hi-z idle", {31'h0, sdo === 1'bz}, 32'h1);

        frame("R3 8-bit ctrl", 64'h5A, 8, 1'b0);
        frame("R4 R2 16-bit N msb-first", 64'hA5C3, 16, 1'b0);
        frame("R5 15-bit R", 64'h7F01 | 64'h4000, 15, 1'b0);
        frame("R5 R7 24-bit R", 64'hC3_96E1, 24, 1'b1);
        frame("R6 12-bit discard", 64'hFFF, 12, 1'b0);
        frame("R12 40-bit saturate", 64'hAB_CD_EF_12_FF, 40, 1'b0);

        // R1: clock toggling with enable high is ignored
        for (int i = 0; i < 5; i++) begin
            sdi = 1'b1; tick(1); sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
        end
        check("R1 oe while enable high", {31'h0, sdo_oe}, 32'h0);
        frame("R1 count starts clean", 64'h3C, 8, 1'b0);

        // R9: enable falls while sclk high
        sclk = 1'b1; tick(2);
        en_n = 1'b0; tick(2);
        check("R9 oe after slip", {31'h0, sdo_oe}, 32'h0);
        sclk = 1'b0; tick(2);
        send_bits(64'h81, 8, 1'b0);
        check("R9 oe in lost frame", {31'h0, sdo_oe}, 32'h0);
        en_n = 1'b1; tick(2);
        expect_regs("R9 start slip discards");

        // R9: enable rises while sclk high at end of an 8-bit frame
        en_n = 1'b0; tick(2);
        send_bits(64'h12, 7, 1'b0);
        sdi = 1'b1; tick(1);
        sclk = 1'b1; tick(2);
        en_n = 1'b1; tick(2);
        sclk = 1'b0; tick(2);
        expect_regs("R9 end slip discards");

        // R10: near-miss exits do not restore sync
        sclk = 1'b1; tick(2);
        en_n = 1'b0; tick(2);
        en_n = 1'b1; tick(2);
        en_n = 1'b0; tick(2);
        sclk = 1'b0; tick(2);
        send_bits(64'hE7, 8, 1'b0);
        check("R10 still lost oe", {31'h0, sdo_oe}, 32'h0);
        en_n = 1'b1; tick(2);
        expect_regs("R10 lost frame ignored");
        frame("R10 after resync", 64'h99, 8, 1'b0);

        // R11: reset clears registers
        rst = 1'b1; tick(2); rst = 1'b0; tick(2);
        mc = '0; mn = '0; mr = '0;
        expect_regs("R11 mid reset");
        frame("R11 sync after reset", 64'h44, 8, 1'b0);

        tick(4);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule